// File: doc/BRIEF.md
# SPI Master with Register-Selected Chip-Select Sequencing

This block is an SPI master meant for serial NOR flash and similar devices. A host issues 16-bit register reads and writes over a simple request/acknowledge bus. One control word sets three things: which of four active-low chip selects to drive, the serial clock divider and the idle level of the serial clock. Data transfers are then started through data registers. The register address alone decides what chip select does when the operation ends. The hold register keeps it asserted. The end register releases it. The stream register overlaps each returned burst word with the shift of the next one.

Each transfer moves 16 bits with the most significant bit first. The chip-select line is taken low when a transfer is launched. The host request is stalled until any access that needs the shifter can complete, and the acknowledge marks that point. A burst starts with a priming read. After that, every read of the stream register returns the word already shifted in and at once launches the next read. The burst is closed by a plain read of the hold or end register. That read takes the word already fetched and does not shift again.

Top module: `spi_autocs_master`

## Requirements
- R1: After reset all chip-select lines are high, SCLK is low, the acknowledge is low and the control word reads back with every bit except bit 15 equal to zero.
- R2: The control word at word address 0 reads back as follows. Bit 15 is the live MISO level and is read-only. Bit 14 is the clock-idle select, bits 13:10 are the speed and bits 9:8 are the chip-select index. Bits 7:0 read as zero. Writes to bit 15 and to bits 7:0 have no effect.
- R3: During a transfer each SCLK half-period lasts one clock cycle at speed 0 and 2n clock cycles at speed n≥1. A full SCLK period at speed n is therefore 2n times longer than at speed 0.
- R4: When speed is 1 or more, SCLK rests at the level of bit 14 while no transfer is running. At speed 0 it rests low whatever bit 14 holds.
- R5: A transfer shifts 16 bits out on MOSI, most significant bit first. MOSI changes only on the trailing SCLK edge. MISO is sampled on the leading edge.
- R6: A write to word address 4 (hold) shifts the written word out. The chip select picked by the index is low during the transfer and stays low after it. The other three stay high, and at most one line is ever low.
- R7: A write to word address 6 (end) shifts the written word out. All chip selects are high once the acknowledge has been returned.
- R8: Word address 1 returns the word received during the most recent write-initiated transfer. Reads of any register leave it unchanged.
- R9: A read of word address 5 (stream) returns the next burst word. The first read of a burst waits for a priming transfer. Every read launches a further transfer at once, with chip select still low. When that word has already arrived, the acknowledge follows within three cycles.
- R10: While a fetched stream word is pending, a read of address 4 or 6 returns that word without another shift. A read of address 6 also raises all chip selects.
- R11: An access that needs the shifter is not acknowledged while a transfer is in progress. A write to the hold or end register is acknowledged only after all 32 SCLK edges. Every acknowledge lasts one cycle.
- R12: A read of address 4 or 6 with no pending stream word shifts out all ones. It returns the word received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Host access request, held until acknowledged |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid with the acknowledge |
| bus_ack | output | 1 | One-cycle completion pulse |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 4 | Active-low chip selects |

## Verification
A broken bit counter or phase flag shows up as a wrong MOSI word at the slave model, or as an SCLK level off its idle value after a transfer. Either one is visible in the same transfer, within 32 edges. A wrong chip-select state appears on the port in the cycle after the acknowledge. A mistracked stream word has two visible effects. The returned data breaks the slave's numbered word sequence within one read. The slave's transfer count also differs from the expected count at the next idle check.

// File: rtl/spi_ac_pkg.sv
package spi_ac_pkg;

   localparam int ADDR_W = 3;

   // word addresses; the data-register address selects the chip-select policy
   typedef enum logic [ADDR_W-1:0] {
      RA_CTRL = 3'd0,
      RA_LAST = 3'd1,
      RA_HOLD = 3'd4,
      RA_STRM = 3'd5,
      RA_END  = 3'd6
   } reg_addr_e;

   typedef enum logic {
      HS_IDLE = 1'b0,
      HS_WAIT = 1'b1
   } host_state_e;

endpackage

// File: rtl/spi_ac_clkdiv.sv
module spi_ac_clkdiv #(
   parameter int SPEED_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic [SPEED_W-1:0] speed,
   output logic               tick
);
   localparam int HP_W = SPEED_W + 1;

   logic [HP_W-1:0] cnt;
   logic [HP_W-1:0] half_per;

   // half-period in clock cycles: 1 at speed 0, 2n otherwise
   assign half_per = (speed == '0) ? HP_W'(1) : {speed, 1'b0};
   assign tick     = run && (HP_W'(cnt + 1'b1) == half_per);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run || tick)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/spi_ac_shifter.sv
module spi_ac_shifter #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] tx_word,
   input  logic              tick,
   input  logic              idle_lvl,
   input  logic              miso,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rx_word,
   output logic              sclk,
   output logic              mosi
);
   localparam int BC_W = $clog2(DATA_W);

   logic [DATA_W-1:0] tx_sh;
   logic [DATA_W-1:0] rx_sh;
   logic [BC_W-1:0]   bit_cnt;
   logic              phase;   // 1 between leading and trailing edge

   assign sclk = phase ^ idle_lvl;
   assign mosi = tx_sh[DATA_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh   <= '0;
         rx_sh   <= '0;
         rx_word <= '0;
         bit_cnt <= '0;
         phase   <= 1'b0;
         busy    <= 1'b0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start) begin
               tx_sh   <= tx_word;
               rx_sh   <= '0;
               bit_cnt <= '0;
               phase   <= 1'b0;
               busy    <= 1'b1;
            end
         end else if (tick) begin
            if (!phase) begin
               phase <= 1'b1;
               rx_sh <= {rx_sh[DATA_W-2:0], miso};
            end else begin
               phase <= 1'b0;
               if (bit_cnt == BC_W'(DATA_W - 1)) begin
                  busy    <= 1'b0;
                  done    <= 1'b1;
                  rx_word <= rx_sh;
               end else begin
                  bit_cnt <= bit_cnt + 1'b1;
                  tx_sh   <= {tx_sh[DATA_W-2:0], 1'b0};
               end
            end
         end
      end
   end
endmodule

// File: rtl/spi_autocs_master.sv
module spi_autocs_master
   import spi_ac_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int NUM_CS  = 4,
   parameter int SPEED_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [2:0]        bus_addr,
   input  logic [15:0]       bus_wdata,
   output logic [15:0]       bus_rdata,
   output logic              bus_ack,
   output logic              spi_sclk,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic [NUM_CS-1:0] spi_cs_n
);
   localparam int CS_W       = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
   localparam int POS_MISO   = DATA_W - 1;
   localparam int POS_CPOL   = DATA_W - 2;
   localparam int POS_SPD_LO = POS_CPOL - SPEED_W;
   localparam int POS_CS_LO  = POS_SPD_LO - CS_W;

   generate
      if (DATA_W != 16) begin : g_bad_width
         $error("spi_autocs_master: the host bus carries 16-bit words");
      end
      if (POS_CS_LO < 0) begin : g_bad_fields
         $error("spi_autocs_master: control fields do not fit the word");
      end
      if (NUM_CS < 1 || NUM_CS > (1 << CS_W)) begin : g_bad_cs
         $error("spi_autocs_master: chip-select count out of range");
      end
   endgenerate

   // control state
   logic               cpol_r;
   logic [SPEED_W-1:0] speed_r;
   logic [CS_W-1:0]    idx_r;
   logic               idle_lvl;

   // chip-select state
   logic               cs_on;
   logic [CS_W-1:0]    cs_sel;

   // host side state
   host_state_e        hst;
   logic               w_we, w_end;
   logic [DATA_W-1:0]  last_rx;
   logic               pf_busy, pf_valid;
   logic [DATA_W-1:0]  pf_data;
   logic               launch_q;
   logic [DATA_W-1:0]  launch_w;
   logic [DATA_W-1:0]  ctrl_rd;

   // engine
   logic               tick, eng_busy, eng_done;
   logic [DATA_W-1:0]  eng_rx;

   assign idle_lvl = cpol_r & (speed_r != '0);

   always_comb begin
      ctrl_rd = '0;
      ctrl_rd[POS_MISO] = spi_miso;
      ctrl_rd[POS_CPOL] = cpol_r;
      ctrl_rd[POS_SPD_LO +: SPEED_W] = speed_r;
      ctrl_rd[POS_CS_LO +: CS_W] = idx_r;
   end

   spi_ac_clkdiv #(.SPEED_W(SPEED_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (eng_busy),
      .speed (speed_r),
      .tick  (tick)
   );

   spi_ac_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (launch_q),
      .tx_word  (launch_w),
      .tick     (tick),
      .idle_lvl (idle_lvl),
      .miso     (spi_miso),
      .busy     (eng_busy),
      .done     (eng_done),
      .rx_word  (eng_rx),
      .sclk     (spi_sclk),
      .mosi     (spi_mosi)
   );

   generate
      for (genvar gi = 0; gi < NUM_CS; gi++) begin : g_cs
         assign spi_cs_n[gi] = !(cs_on && (cs_sel == CS_W'(gi)));
      end
   endgenerate

   wire shifter_free = !eng_busy && !pf_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpol_r    <= 1'b0;
         speed_r   <= '0;
         idx_r     <= '0;
         cs_on     <= 1'b0;
         cs_sel    <= '0;
         hst       <= HS_IDLE;
         w_we      <= 1'b0;
         w_end     <= 1'b0;
         last_rx   <= '0;
         pf_busy   <= 1'b0;
         pf_valid  <= 1'b0;
         pf_data   <= '0;
         launch_q  <= 1'b0;
         launch_w  <= '0;
         bus_ack   <= 1'b0;
         bus_rdata <= '0;
      end else begin
         bus_ack  <= 1'b0;
         launch_q <= 1'b0;
         if (eng_done && pf_busy) begin
            pf_busy  <= 1'b0;
            pf_valid <= 1'b1;
            pf_data  <= eng_rx;
         end
         unique case (hst)
            HS_IDLE: if (bus_req && !bus_ack) begin
               case (bus_addr)
                  RA_CTRL: begin
                     if (bus_we) begin
                        cpol_r  <= bus_wdata[POS_CPOL];
                        speed_r <= bus_wdata[POS_SPD_LO +: SPEED_W];
                        idx_r   <= bus_wdata[POS_CS_LO +: CS_W];
                     end else
                        bus_rdata <= ctrl_rd;
                     bus_ack <= 1'b1;
                  end
                  RA_LAST: begin
                     if (!bus_we) bus_rdata <= last_rx;
                     bus_ack <= 1'b1;
                  end
                  RA_STRM: begin
                     if (bus_we)
                        bus_ack <= 1'b1;
                     else if (shifter_free) begin
                        if (pf_valid) begin
                           bus_rdata <= pf_data;
                           pf_valid  <= 1'b0;
                           bus_ack   <= 1'b1;
                        end
                        launch_q <= 1'b1;
                        launch_w <= '1;
                        pf_busy  <= 1'b1;
                        cs_on    <= 1'b1;
                        cs_sel   <= idx_r;
                     end
                  end
                  RA_HOLD, RA_END: if (shifter_free) begin
                     if (!bus_we && pf_valid) begin
                        bus_rdata <= pf_data;
                        pf_valid  <= 1'b0;
                        bus_ack   <= 1'b1;
                        if (bus_addr == RA_END) cs_on <= 1'b0;
                     end else begin
                        pf_valid <= 1'b0;
                        launch_q <= 1'b1;
                        launch_w <= bus_we ? bus_wdata : '1;
                        cs_on    <= 1'b1;
                        cs_sel   <= idx_r;
                        w_we     <= bus_we;
                        w_end    <= (bus_addr == RA_END);
                        hst      <= HS_WAIT;
                     end
                  end
                  default: begin
                     bus_rdata <= '0;
                     bus_ack   <= 1'b1;
                  end
               endcase
            end
            HS_WAIT: if (eng_done) begin
               if (w_we) last_rx <= eng_rx;
               bus_rdata <= eng_rx;
               bus_ack   <= 1'b1;
               if (w_end) cs_on <= 1'b0;
               hst <= HS_IDLE;
            end
            default: hst <= HS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/spi_autocs_master_chk.sv
module spi_autocs_master_chk #(
   parameter int NUM_CS = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_ack,
   input logic              spi_sclk,
   input logic              spi_mosi,
   input logic [NUM_CS-1:0] spi_cs_n,
   input logic              eng_busy,
   input logic              pf_busy,
   input logic              idle_lvl
);
   assert_cs_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~spi_cs_n) <= 1);

   assert_sclk_rest_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !eng_busy |-> spi_sclk == idle_lvl);

   assert_mosi_steady_lead_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!(&spi_cs_n) && spi_sclk != $past(spi_sclk) && spi_sclk != idle_lvl)
      |-> $stable(spi_mosi));

   assert_ack_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ack |=> !bus_ack);

   assert_no_ack_midshift_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_busy && !pf_busy) |-> !bus_ack);
endmodule

bind spi_autocs_master spi_autocs_master_chk #(.NUM_CS(NUM_CS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_ack  (bus_ack),
   .spi_sclk (spi_sclk),
   .spi_mosi (spi_mosi),
   .spi_cs_n (spi_cs_n),
   .eng_busy (eng_busy),
   .pf_busy  (pf_busy),
   .idle_lvl (idle_lvl)
);

// File: tb/spi_autocs_master_tb_top.sv
`timescale 1ns/1ps
module spi_autocs_master_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0, bus_we = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        bus_ack, spi_sclk, spi_mosi, spi_miso;
   logic [3:0]  spi_cs_n;

   int n_checks = 0, n_err = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   spi_autocs_master dut_i (.*);

   // ---------------- slave model ----------------
   function automatic logic [15:0] resp(int k);
      return 16'hA5C3 ^ 16'((k + 1) * 16'h1357);
   endfunction

   logic [15:0] s_tx, s_rx, s_last;
   int          s_bits = 0, s_cnt = 0;
   logic        idle_b = 1'b0;
   initial s_tx = resp(0);
   assign spi_miso = s_tx[15];

   always @(spi_sclk) begin
      if (spi_cs_n !== 4'hF) begin
         if (spi_sclk != idle_b) begin
            s_rx = {s_rx[14:0], spi_mosi};
            s_bits++;
         end else begin
            s_tx = {s_tx[14:0], 1'b0};
            if (s_bits == 16) begin
               s_last = s_rx;
               s_cnt++;
               s_tx = resp(s_cnt);
               s_bits = 0;
            end
         end
      end
   end

   // half-period monitor
   logic sclk_prev = 1'b0;
   int   run_len = 0, hp_meas = 0;
   always @(negedge clk) begin
      if (spi_sclk !== sclk_prev) begin hp_meas = run_len; run_len = 1; end
      else run_len++;
      sclk_prev = spi_sclk;
   end

   // ---------------- helpers ----------------
   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus(input bit we, input logic [2:0] a, input logic [15:0] wd,
                      output logic [15:0] rd, output int cyc);
      @(negedge clk);
      bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = wd; cyc = 0;
      do begin @(negedge clk); cyc++; end while (!bus_ack && cyc < 20000);
      rd = bus_rdata;
      bus_req = 1'b0;
   endtask

   task automatic set_ctrl(input bit cpol, input int spd, input int lun);
      logic [15:0] rd; int cyc;
      bus(1'b1, 3'd0, {1'b0, cpol, 4'(spd), 2'(lun), 8'h00}, rd, cyc);
      idle_b = cpol & (spd != 0);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run;
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
         $finish;
      end
   endtask

   initial begin
      #(20ns * 150000);
      n_checks++; n_err++;
      $display("FAIL R11 watchdog actual=hung expected=complete");
      finish_run();
   end

   // ---------------- stimulus ----------------
   initial begin
      logic [15:0] rd, d;
      int cyc, k, spd, lun, c0;
      bit cpol;
      void'($urandom(32'h5EED1234));
      repeat (5) @(negedge clk);
      chk(spi_cs_n == 4'hF, "R1 cs_n", 32'(spi_cs_n), 32'hF);
      chk(spi_sclk == 1'b0, "R1 sclk", 32'(spi_sclk), 0);
      chk(bus_ack == 1'b0, "R1 ack", 32'(bus_ack), 0);
      rst_n = 1'b1;
      idle(2);
      bus(1'b0, 3'd0, 16'h0, rd, cyc);
      chk(rd == {spi_miso, 15'h0}, "R1 ctrl reset", 32'(rd), 32'({spi_miso, 15'h0}));

      // R2 field readback, reserved and MISO bits ignored on write
      bus(1'b1, 3'd0, 16'hFFFF, rd, cyc);
      idle_b = 1'b1;
      bus(1'b0, 3'd0, 16'h0, rd, cyc);
      chk(rd == {spi_miso, 15'h7F00}, "R2 ctrl readback", 32'(rd), 32'({spi_miso, 15'h7F00}));
      chk(spi_sclk == 1'b1, "R4 idle high cpol1", 32'(spi_sclk), 1);
      set_ctrl(1'b1, 0, 1);
      idle(1);
      chk(spi_sclk == 1'b0, "R4 speed0 idle low", 32'(spi_sclk), 0);

      // directed hold then end writes at speed 0
      k = s_cnt;
      bus(1'b1, 3'd4, 16'h1234, rd, cyc);
      chk(cyc > 32, "R11 hold write waits", 32'(cyc), 33);
      chk(s_last == 16'h1234, "R5 mosi word", 32'(s_last), 32'h1234);
      chk(spi_cs_n == 4'b1101, "R6 hold keeps cs", 32'(spi_cs_n), 32'hD);
      chk(hp_meas == 1, "R3 speed0 half period", 32'(hp_meas), 1);
      bus(1'b0, 3'd1, 16'h0, rd, cyc);
      chk(rd == resp(k), "R8 last rx", 32'(rd), 32'(resp(k)));
      bus(1'b1, 3'd6, 16'hBEEF, rd, cyc);
      chk(spi_cs_n == 4'hF, "R7 end releases cs", 32'(spi_cs_n), 32'hF);
      chk(s_last == 16'hBEEF, "R5 mosi word end", 32'(s_last), 32'hBEEF);

      // random transfers
      for (int it = 0; it < 20; it++) begin
         spd = $urandom_range(0, 4);
         cpol = 1'($urandom_range(0, 1));
         lun = $urandom_range(0, 3);
         set_ctrl(cpol, spd, lun);
         idle(1);
         chk(spi_sclk == (cpol & (spd != 0)), "R4 idle level", 32'(spi_sclk), 32'(cpol & (spd != 0)));
         for (int t = 0; t <= $urandom_range(0, 2); t++) begin
            d = 16'($urandom());
            k = s_cnt;
            bus(1'b1, 3'd4, d, rd, cyc);
            chk(s_last == d, "R5 hold data", 32'(s_last), 32'(d));
            chk(spi_cs_n == ~(4'b1 << lun), "R6 hold cs", 32'(spi_cs_n), 32'(~(4'b1 << lun)));
            bus(1'b0, 3'd1, 16'h0, rd, cyc);
            chk(rd == resp(k), "R8 last rx hold", 32'(rd), 32'(resp(k)));
         end
         d = 16'($urandom());
         k = s_cnt;
         bus(1'b1, 3'd6, d, rd, cyc);
         chk(s_last == d, "R5 end data", 32'(s_last), 32'(d));
         chk(spi_cs_n == 4'hF, "R7 end cs", 32'(spi_cs_n), 32'hF);
         chk(hp_meas == ((spd == 0) ? 1 : 2 * spd), "R3 half period", 32'(hp_meas), 32'((spd == 0) ? 1 : 2 * spd));
         chk(spi_sclk == (cpol & (spd != 0)), "R4 rest after xfer", 32'(spi_sclk), 32'(cpol & (spd != 0)));
         bus(1'b0, 3'd1, 16'h0, rd, cyc);
         chk(rd == resp(k), "R8 last rx end", 32'(rd), 32'(resp(k)));
      end

      // R12 plain reads shift all ones; R8 unchanged by reads
      set_ctrl(1'b0, 2, 3);
      bus(1'b1, 3'd4, 16'h0F0F, rd, cyc);
      d = 16'(resp(s_cnt - 1));
      k = s_cnt;
      bus(1'b0, 3'd4, 16'h0, rd, cyc);
      chk(rd == resp(k), "R12 hold read data", 32'(rd), 32'(resp(k)));
      chk(s_last == 16'hFFFF, "R12 ones shifted", 32'(s_last), 32'hFFFF);
      k = s_cnt;
      bus(1'b0, 3'd6, 16'h0, rd, cyc);
      chk(rd == resp(k), "R12 end read data", 32'(rd), 32'(resp(k)));
      chk(spi_cs_n == 4'hF, "R7 end read cs", 32'(spi_cs_n), 32'hF);
      bus(1'b0, 3'd1, 16'h0, rd, cyc);
      chk(rd == d, "R8 reads leave last rx", 32'(rd), 32'(d));

      // R9/R10 pipelined burst
      set_ctrl(1'b0, 1, 2);
      c0 = s_cnt;
      for (int i = 0; i < 5; i++) begin
         if (i == 2) idle(200);
         bus(1'b0, 3'd5, 16'h0, rd, cyc);
         chk(rd == resp(c0 + i), "R9 stream word", 32'(rd), 32'(resp(c0 + i)));
         if (i == 2) chk(cyc <= 3, "R9 prefetched latency", 32'(cyc), 3);
         chk(spi_cs_n == 4'b1011, "R9 cs held", 32'(spi_cs_n), 32'hB);
      end
      bus(1'b0, 3'd0, 16'h0, rd, cyc);
      chk(cyc <= 3, "R11 ctrl not stalled by readahead", 32'(cyc), 3);
      idle(200);
      chk(s_cnt == c0 + 6, "R9 readahead launched", 32'(s_cnt), 32'(c0 + 6));
      chk(s_last == 16'hFFFF, "R9 readahead sends ones", 32'(s_last), 32'hFFFF);
      bus(1'b0, 3'd6, 16'h0, rd, cyc);
      chk(rd == resp(c0 + 5), "R10 pending word", 32'(rd), 32'(resp(c0 + 5)));
      idle(100);
      chk(s_cnt == c0 + 6, "R10 no extra shift", 32'(s_cnt), 32'(c0 + 6));
      chk(spi_cs_n == 4'hF, "R10 end read releases", 32'(spi_cs_n), 32'hF);

      finish_run();
   end
endmodule